// File: doc/BRIEF.md
# Page Write Collector and Programming Sequencer

This block sits behind the serial protocol engine of a byte-addressed non-volatile memory. It gathers the data bytes of one write command into a page buffer, then commits them to the storage array after a self-timed programming interval. The protocol engine hands it a start address with a write-protect flag, one strobe per received data byte, and pulses for STOP and for a repeated START. The block returns a busy flag that tells the protocol engine to ignore the bus. It also drives a byte write port into a synchronous RAM that models the array.

The write address advances with every byte but stays inside the page of the start address. When more bytes arrive than the page holds, the later bytes replace the earlier ones. A STOP that ends a command carrying at least one byte, with the write-protect flag clear, starts a countdown of `PROG_CYCLES` clocks. After the countdown the buffer is scanned one slot per clock and every filled slot is written. Busy then drops and the buffer is empty again.

Top module: `eep_page_writer`

## Requirements
- R1: After reset, busy and mem_we are low.
- R2: A single data byte is written to exactly the start address. The page is the address bits above the lowest five, and the slot is the lowest five bits.
- R3: Each further byte of a command goes to the next slot. The slot wraps from 31 to 0 inside the start page, and the page bits never change.
- R4: When a command carries more than 32 bytes, byte k lands in the same slot as byte k-32, and the last byte to arrive in a slot is the one committed.
- R5: No write and no busy occur while bytes are being received. Busy rises on the clock edge that samples bus_stop.
- R6: Busy stays high for exactly PROG_CYCLES + 32 clock cycles.
- R7: Writes occur only in the last 32 busy cycles, one slot per cycle in ascending slot order. Each filled slot is written once, and empty slots are not written.
- R8: A command whose load_wp was 1 at addr_load commits nothing and never raises busy.
- R9: A STOP after an address with zero data bytes commits nothing and never raises busy.
- R10: A bus_restart before STOP discards the collected bytes, and a STOP that follows commits nothing.
- R11: While busy, addr_load, byte_stb and bus_stop have no effect. Only the bytes of the original command are written, and no second busy interval follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Pulse: a write command's two address bytes are complete |
| load_addr | input | ADDR_W | Start address, valid with addr_load |
| load_wp | input | 1 | Write-protect flag latched by the protocol engine, valid with addr_load |
| byte_stb | input | 1 | Pulse: one data byte received |
| byte_data | input | 8 | Data byte, valid with byte_stb |
| bus_stop | input | 1 | Pulse: STOP seen on the bus |
| bus_restart | input | 1 | Pulse: repeated START seen before STOP |
| busy | output | 1 | Programming in progress; the bus must be ignored |
| mem_we | output | 1 | RAM byte write enable |
| mem_addr | output | ADDR_W | RAM byte address |
| mem_wdata | output | 8 | RAM write data |

## Verification
The bound checker watches several rules on every clock cycle:
- a write only happens while busy, and only in the commit phase with the protect flag clear;
- the page bits stay fixed across the commit phase, and the slot steps up by one each cycle;
- busy rises only after a STOP, and it never re-rises on the cycle right after it falls;
- the length of each busy interval is counted against PROG_CYCLES + 32.

Other behaviour shows only in the bench scenarios, because it depends on what a whole command sent:
- which data lands in which slot after a wrap or an overflow;
- that protected, empty or cancelled commands leave the RAM untouched;
- that bus activity during busy is dropped.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_PROG    = 2'd2,
    ST_COMMIT  = 2'd3
  } pgw_state_t;
endpackage

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
  parameter int PAGE_BYTES = 32,
  localparam int SLOT_W = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [7:0]        wr_data,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [7:0]        rd_data,
  output logic              rd_full,
  output logic              any_full
);
  logic [7:0]            data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
    end else if (clr) begin
      full_q <= '0;
    end else if (wr_en) begin
      full_q[wr_slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_slot] <= wr_data;
  end

  assign rd_data  = data_q[rd_slot];
  assign rd_full  = full_q[rd_slot];
  assign any_full = |full_q;
endmodule

// File: rtl/pgw_prog_timer.sv
module pgw_prog_timer #(
  parameter int PROG_CYCLES = 625000,
  localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CNT_W'(PROG_CYCLES - 1);
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/eep_page_writer.sv
module eep_page_writer #(
  parameter int ADDR_W      = 13,
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 625000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              load_wp,
  input  logic              byte_stb,
  input  logic [7:0]        byte_data,
  input  logic              bus_stop,
  input  logic              bus_restart,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  import pgw_pkg::*;

  localparam int SLOT_W = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - SLOT_W;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(PAGE_BYTES - 1);

  function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:SLOT_W];
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
    return a[SLOT_W-1:0];
  endfunction

  function automatic logic [SLOT_W-1:0] slot_next(input logic [SLOT_W-1:0] s);
    return s + SLOT_W'(1);
  endfunction

  pgw_state_t        st_q;
  logic [PAGE_W-1:0] page_q;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] idx_q;
  logic              wp_q;

  // named internal events
  logic take_addr, take_byte, cancel, stop_seen, commit_go, commit_phase, commit_last;
  logic expired, rd_full, any_full, buf_clr;
  logic [7:0] rd_data;

  assign take_addr    = (st_q == ST_IDLE || st_q == ST_COLLECT) && addr_load;
  assign cancel       = (st_q == ST_COLLECT) && bus_restart && !addr_load;
  assign stop_seen    = (st_q == ST_COLLECT) && bus_stop && !bus_restart && !addr_load;
  assign take_byte    = (st_q == ST_COLLECT) && byte_stb && !bus_stop && !bus_restart && !addr_load;
  assign commit_go    = stop_seen && any_full && !wp_q;
  assign commit_phase = (st_q == ST_COMMIT);
  assign commit_last  = commit_phase && (idx_q == LAST_SLOT);
  assign buf_clr      = take_addr || commit_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      page_q <= '0;
      slot_q <= '0;
      idx_q  <= '0;
      wp_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_COLLECT: begin
          if (take_addr) begin
            st_q   <= ST_COLLECT;
            page_q <= page_of(load_addr);
            slot_q <= slot_of(load_addr);
            wp_q   <= load_wp;
          end else if (cancel) begin
            st_q <= ST_IDLE;
          end else if (stop_seen) begin
            st_q <= commit_go ? ST_PROG : ST_IDLE;
          end else if (take_byte) begin
            slot_q <= slot_next(slot_q);
          end
        end
        ST_PROG: begin
          if (expired) begin
            st_q  <= ST_COMMIT;
            idx_q <= '0;
          end
        end
        ST_COMMIT: begin
          if (commit_last) st_q <= ST_IDLE;
          idx_q <= slot_next(idx_q);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  pgw_page_buf #(.PAGE_BYTES(PAGE_BYTES)) buf_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (buf_clr),
    .wr_en    (take_byte),
    .wr_slot  (slot_q),
    .wr_data  (byte_data),
    .rd_slot  (idx_q),
    .rd_data  (rd_data),
    .rd_full  (rd_full),
    .any_full (any_full)
  );

  pgw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) tmr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (commit_go),
    .run     (st_q == ST_PROG),
    .expired (expired)
  );

  assign busy      = (st_q == ST_PROG) || commit_phase;
  assign mem_we    = commit_phase && rd_full;
  assign mem_addr  = {page_q, idx_q};
  assign mem_wdata = rd_data;
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
  parameter int ADDR_W      = 13,
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 625000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_stop,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              commit_phase,
  input logic              wp_q
);
  localparam int SLOT_W = $clog2(PAGE_BYTES);
  localparam int TOTAL  = PROG_CYCLES + PAGE_BYTES;

  logic [31:0] busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 32'd1;
    else           busy_len <= '0;
  end

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> (!busy && !mem_we));

  p_busy_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_stop));

  p_busy_length_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == 32'(TOTAL)));

  p_write_in_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (busy && commit_phase));

  p_slot_ascends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_phase && $past(commit_phase)) |->
      (mem_addr[SLOT_W-1:0] == $past(mem_addr[SLOT_W-1:0]) + SLOT_W'(1)));

  p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_phase && $past(commit_phase)) |-> $stable(mem_addr[ADDR_W-1:SLOT_W]));

  p_protect_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !wp_q);

  p_no_rebusy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> !busy);
endmodule

bind eep_page_writer pgw_checker #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_stop     (bus_stop),
  .busy         (busy),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .commit_phase (commit_phase),
  .wp_q         (wp_q)
);

// File: tb/eep_page_writer_tb_top.sv
module eep_page_writer_tb_top;
  localparam int ADDR_W = 13;
  localparam int PAGE   = 32;
  localparam int PROG   = 20;
  localparam int TOTAL  = PROG + PAGE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_load = 1'b0, load_wp = 1'b0, byte_stb = 1'b0, bus_stop = 1'b0, bus_restart = 1'b0;
  logic [ADDR_W-1:0] load_addr = '0;
  logic [7:0] byte_data = '0;
  logic busy, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata;

  int nchk = 0, nerr = 0;
  int wr_a [64];
  int wr_d [64];
  int nwr;
  int busy_len;
  int pre_bad;
  int exp_a [64];
  int exp_d [64];
  int nexp;

  always #4 clk = ~clk;

  eep_page_writer #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE), .PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .load_addr(load_addr), .load_wp(load_wp),
    .byte_stb(byte_stb), .byte_data(byte_data), .bus_stop(bus_stop), .bus_restart(bus_restart),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // sends one command; inputs change on falling edges
  task automatic send_cmd(int addr, int nbytes, int base, bit wp, bit restart, bit stop);
    pre_bad = 0;
    @(negedge clk);
    addr_load = 1'b1; load_addr = ADDR_W'(addr); load_wp = wp;
    @(negedge clk);
    addr_load = 1'b0; load_wp = 1'b0;
    for (int i = 0; i < nbytes; i++) begin
      byte_stb = 1'b1; byte_data = 8'(base + i);
      @(negedge clk);
      byte_stb = 1'b0;
      if (busy || mem_we) pre_bad++;
    end
    if (restart) begin
      bus_restart = 1'b1;
      @(negedge clk);
      bus_restart = 1'b0;
    end
    if (stop) begin
      bus_stop = 1'b1;
      @(negedge clk);
      bus_stop = 1'b0;
    end
  endtask

  // follows one busy interval, logging writes; optionally disturbs the bus meanwhile
  task automatic follow_busy(bit disturb);
    nwr = 0; busy_len = 0;
    while (busy && busy_len < 1000) begin
      if (mem_we && nwr < 64) begin
        wr_a[nwr] = int'(mem_addr); wr_d[nwr] = int'(mem_wdata); nwr++;
      end
      busy_len++;
      if (disturb) begin
        addr_load = (busy_len == 3); load_addr = ADDR_W'(16'h0300);
        byte_stb  = (busy_len == 4); byte_data = 8'h77;
        bus_stop  = (busy_len == 5);
      end
      @(negedge clk);
    end
    addr_load = 1'b0; byte_stb = 1'b0; bus_stop = 1'b0;
  endtask

  task automatic compare_writes(string req);
    check_eq(req, "write count", nwr, nexp);
    for (int i = 0; i < nexp && i < nwr; i++) begin
      check_eq(req, $sformatf("write %0d addr", i), wr_a[i], exp_a[i]);
      check_eq(req, $sformatf("write %0d data", i), wr_d[i], exp_d[i]);
    end
  endtask

  task automatic expect_quiet(string req, int cycles);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      if (busy || mem_we) seen++;
      @(negedge clk);
    end
    check_eq(req, "busy/we cycles while quiet", seen, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_eq("R1", "busy after reset", int'(busy), 0);
    check_eq("R1", "mem_we after reset", int'(mem_we), 0);
  endtask

  task automatic t_byte_write();
    send_cmd(16'h0105, 1, 8'hA5, 1'b0, 1'b0, 1'b1);
    check_eq("R5", "busy or we while collecting", pre_bad, 0);
    check_eq("R5", "busy right after stop", int'(busy), 1);
    follow_busy(1'b0);
    check_eq("R6", "busy length", busy_len, TOTAL);
    nexp = 1; exp_a[0] = 16'h0105; exp_d[0] = 8'hA5;
    compare_writes("R2");
  endtask

  task automatic t_page_wrap();
    send_cmd(16'h003E, 4, 8'h50, 1'b0, 1'b0, 1'b1);
    follow_busy(1'b0);
    check_eq("R6", "busy length wrap", busy_len, TOTAL);
    nexp = 4;
    exp_a[0] = 16'h0020; exp_d[0] = 8'h52;
    exp_a[1] = 16'h0021; exp_d[1] = 8'h53;
    exp_a[2] = 16'h003E; exp_d[2] = 8'h50;
    exp_a[3] = 16'h003F; exp_d[3] = 8'h51;
    compare_writes("R3");
  endtask

  task automatic t_overflow();
    send_cmd(16'h0040, 34, 8'h10, 1'b0, 1'b0, 1'b1);
    follow_busy(1'b0);
    nexp = 32;
    for (int s = 0; s < 32; s++) begin
      exp_a[s] = 16'h0040 + s;
      exp_d[s] = (s < 2) ? 8'h30 + s : 8'h10 + s;
    end
    compare_writes("R4");
    check_eq("R7", "commit writes in ascending order, first slot", wr_a[0], 16'h0040);
  endtask

  task automatic t_protect();
    send_cmd(16'h0123, 3, 8'h60, 1'b1, 1'b0, 1'b1);
    expect_quiet("R8", PROG + PAGE + 8);
  endtask

  task automatic t_zero_bytes();
    send_cmd(16'h0200, 0, 0, 1'b0, 1'b0, 1'b1);
    expect_quiet("R9", PROG + PAGE + 8);
  endtask

  task automatic t_restart();
    send_cmd(16'h0210, 2, 8'h70, 1'b0, 1'b1, 1'b1);
    expect_quiet("R10", PROG + PAGE + 8);
  endtask

  task automatic t_busy_ignore();
    send_cmd(16'h0200, 1, 8'h11, 1'b0, 1'b0, 1'b1);
    follow_busy(1'b1);
    check_eq("R11", "busy length with bus activity", busy_len, TOTAL);
    nexp = 1; exp_a[0] = 16'h0200; exp_d[0] = 8'h11;
    compare_writes("R11");
    expect_quiet("R11", PROG + PAGE + 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_byte_write();
    t_page_wrap();
    t_overflow();
    t_protect();
    t_zero_bytes();
    t_restart();
    t_busy_ignore();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule